// File: doc/BRIEF.md
# Dead-Battery Status Output Controller

This block sits behind a USB charger-type detector and turns its result into four status controls: a charger-present flag, a charge-permitted flag, a request to open the isolation switch between the connector data lines and the local transceiver, and an enable for the small D+ bias source. The bias source tells the host that a device with a flat battery is drawing current.

When the detector reports completion, the controller latches the port type and starts a dead-battery timer. The nominal interval is 30 minutes, and the configured interval must stay below 45 minutes. While the timer runs, the switch and D+ source policy depends on the port type and on a filtered copy of the good-battery input. That filtered copy commits rises and falls only after separate, configurable delays. Toggling the battery does not restart the timer.

If the filtered battery is low when the timer expires, the block latches a fault and releases every output. The fault is also entered when the battery drops after a good-battery expiry. Only loss of bus supply clears the fault. The next detection then starts from scratch. All intervals are counted in ticks of a parameterised prescaler.

Top module: `dbat_status_ctrl`

## Requirements
- R1: After reset, and while bus supply is valid but no detection has been accepted, the outputs are in the released state: chg_det_o=0, chg_allow_o=0, sw_open_o=1, dp_src_o=0.
- R2: A det_done_i pulse is accepted only in the idle state while bus_valid_i is high. All four outputs take their new values at the same clock edge that accepts it. The port code is latched at that edge: 2'b00 standard host, 2'b01 charging host, 2'b10 dedicated charger, and 2'b11 treated as a standard host.
- R3: Outside fault and idle, chg_allow_o is 1 for every port code. chg_det_o is 1 only for codes 2'b01 and 2'b10.
- R4: For host ports (codes 00, 01, 11) during the timed period, a good filtered battery gives sw_open_o=0 and dp_src_o=0, and a low filtered battery gives sw_open_o=1 and dp_src_o=1.
- R5: For a dedicated charger (code 10), sw_open_o=1 and dp_src_o=1 whatever the battery state, until fault or idle.
- R6: At acceptance the filtered battery is loaded from good_bat_i directly. Afterwards, a rise is committed at the CLOSE_TICKS-th consecutive tick with the input high, and a fall at the OPEN_TICKS-th consecutive tick with the input low. A shorter excursion has no effect.
- R7: Ticks occur every CLK_PER_TICK cycles, counted from acceptance. The timer expires on the LIMIT_TICKS-th tick, and battery changes do not restart it.
- R8: If the filtered battery is low at expiry, the block enters fault. In fault the outputs are released, and good_bat_i and det_done_i are ignored while bus_valid_i stays high.
- R9: If the filtered battery is good at expiry, outputs keep their charger and charge flags, and host ports get sw_open_o=!battery and dp_src_o=0. A later committed battery fall enters fault.
- R10: One edge after bus_valid_i is seen low, the block is idle with released outputs, from any state. The next accepted detection restarts the timer from zero.
- R11: det_done_i and port_type_i are ignored outside idle. The latched port and the timer are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus supply above its valid threshold |
| det_done_i | input | 1 | Pulse: charger detection finished |
| port_type_i | input | 2 | Detected port code, sampled with det_done_i |
| good_bat_i | input | 1 | Debounced good-battery level |
| chg_det_o | output | 1 | Charger-type port detected |
| chg_allow_o | output | 1 | Charge may be drawn from the bus |
| sw_open_o | output | 1 | Data isolation switch open request |
| dp_src_o | output | 1 | D+ bias source enable |

## Verification
The assertions assume that bus_valid_i and good_bat_i are synchronous, glitch-free levels. They also assume that det_done_i means something only while bus_valid_i is high, so any output rise can be traced to an accepted detection. The stimulus changes inputs only a short time after a clock edge and holds each level for whole cycles. It exercises every port code, battery excursions both shorter and longer than the filter delays, expiry with each battery state, and bus loss in the timed state, the fault state and the post-expiry state. A small prescaler and short limit keep every interval to a few hundred cycles.

// File: rtl/dbat_pkg.sv
package dbat_pkg;

  typedef enum logic [1:0] {
    PORT_STD_HOST = 2'b00,
    PORT_CHG_HOST = 2'b01,
    PORT_WALL     = 2'b10,
    PORT_RSVD     = 2'b11
  } port_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TIMED = 2'd1,
    PH_HELD  = 2'd2,
    PH_FAULT = 2'd3
  } phase_e;

  typedef struct packed {
    logic chg_det;
    logic chg_allow;
    logic sw_open;
    logic dp_src;
  } stat_t;

  localparam stat_t STAT_RELEASED = '{chg_det: 1'b0, chg_allow: 1'b0,
                                      sw_open: 1'b1, dp_src: 1'b0};

endpackage

// File: rtl/dbat_tick_gen.sv
module dbat_tick_gen #(
  parameter int unsigned CLK_PER_TICK = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);

  generate
    if (CLK_PER_TICK <= 1) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_count
      localparam int unsigned CW = $clog2(CLK_PER_TICK);
      localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);
      logic [CW-1:0] cnt_q;

      assign tick_o = run_i && (cnt_q == LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       cnt_q <= '0;
        else if (!run_i)   cnt_q <= '0;
        else if (tick_o)   cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/dbat_limit_timer.sv
module dbat_limit_timer #(
  parameter int unsigned LIMIT_TICKS = 1800000,
  localparam int unsigned TW = $clog2(LIMIT_TICKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          tick_i,
  output logic          expire_o,
  output logic [TW-1:0] cnt_o
);

  localparam logic [TW-1:0] LAST = TW'(LIMIT_TICKS - 1);
  logic [TW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == LAST);
  assign cnt_o    = cnt_q;

  // Saturates at LIMIT_TICKS: once expired, run_i is dropped by the owner.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/dbat_bat_filter.sv
module dbat_bat_filter #(
  parameter int unsigned CLOSE_TICKS = 20,
  parameter int unsigned OPEN_TICKS  = 50,
  localparam int unsigned MAXD = (CLOSE_TICKS > OPEN_TICKS) ? CLOSE_TICKS : OPEN_TICKS,
  localparam int unsigned DW = $clog2(MAXD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic clr_i,
  input  logic track_i,
  input  logic tick_i,
  input  logic raw_i,
  output logic ok_o
);

  localparam logic [DW-1:0] RISE_LAST = DW'(CLOSE_TICKS - 1);
  localparam logic [DW-1:0] FALL_LAST = DW'(OPEN_TICKS - 1);

  logic          ok_q;
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] last;

  assign last = raw_i ? RISE_LAST : FALL_LAST;
  assign ok_o = ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q  <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      ok_q  <= raw_i;
      cnt_q <= '0;
    end else if (clr_i) begin
      ok_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!track_i || (raw_i == ok_q)) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == last) begin
        ok_q  <= raw_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dbat_status_ctrl.sv
module dbat_status_ctrl
  import dbat_pkg::*;
#(
  parameter int unsigned CLK_PER_TICK = 50000,
  parameter int unsigned LIMIT_TICKS  = 1800000,
  parameter int unsigned CLOSE_TICKS  = 20,
  parameter int unsigned OPEN_TICKS   = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_valid_i,
  input  logic       det_done_i,
  input  logic [1:0] port_type_i,
  input  logic       good_bat_i,
  output logic       chg_det_o,
  output logic       chg_allow_o,
  output logic       sw_open_o,
  output logic       dp_src_o
);

  localparam int unsigned TW = $clog2(LIMIT_TICKS + 1);

  phase_e  phase_q, phase_d;
  port_e   port_q;
  logic    accept, tick, expire, bat_ok;
  logic [TW-1:0] tcnt;
  stat_t   stat;

  assign accept = (phase_q == PH_IDLE) && bus_valid_i && det_done_i;

  dbat_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (phase_q != PH_IDLE),
    .tick_o (tick)
  );

  dbat_limit_timer #(.LIMIT_TICKS(LIMIT_TICKS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (phase_q == PH_IDLE),
    .run_i    (phase_q == PH_TIMED),
    .tick_i   (tick),
    .expire_o (expire),
    .cnt_o    (tcnt)
  );

  dbat_bat_filter #(.CLOSE_TICKS(CLOSE_TICKS), .OPEN_TICKS(OPEN_TICKS)) u_bat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .clr_i   (phase_q == PH_IDLE),
    .track_i ((phase_q == PH_TIMED) || (phase_q == PH_HELD)),
    .tick_i  (tick),
    .raw_i   (good_bat_i),
    .ok_o    (bat_ok)
  );

  always_comb begin
    phase_d = phase_q;
    if (!bus_valid_i) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE:  if (det_done_i) phase_d = PH_TIMED;
        PH_TIMED: if (expire)     phase_d = bat_ok ? PH_HELD : PH_FAULT;
        PH_HELD:  if (!bat_ok)    phase_d = PH_FAULT;
        default:  phase_d = PH_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      port_q  <= PORT_STD_HOST;
    end else begin
      phase_q <= phase_d;
      if (accept) port_q <= port_e'(port_type_i);
    end
  end

  // Output decode: every output derives from the same state flops.
  always_comb begin
    stat = STAT_RELEASED;
    if ((phase_q == PH_TIMED) || (phase_q == PH_HELD)) begin
      stat.chg_allow = 1'b1;
      stat.chg_det   = (port_q == PORT_CHG_HOST) || (port_q == PORT_WALL);
      if (port_q == PORT_WALL) begin
        stat.sw_open = 1'b1;
        stat.dp_src  = 1'b1;
      end else begin
        stat.sw_open = !bat_ok;
        stat.dp_src  = !bat_ok && (phase_q == PH_TIMED);
      end
    end
  end

  assign chg_det_o   = stat.chg_det;
  assign chg_allow_o = stat.chg_allow;
  assign sw_open_o   = stat.sw_open;
  assign dp_src_o    = stat.dp_src;

endmodule

// File: rtl/dbat_status_ctrl_chk.sv
module dbat_status_ctrl_chk
  import dbat_pkg::*;
#(
  parameter int unsigned LIMIT_TICKS = 1800000,
  localparam int unsigned TW = $clog2(LIMIT_TICKS + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_valid_i,
  input logic          det_done_i,
  input logic          chg_det_o,
  input logic          chg_allow_o,
  input logic          sw_open_o,
  input logic          dp_src_o,
  input logic [1:0]    phase_i,
  input logic [TW-1:0] tcnt_i
);

  a_r10_release_on_bus_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_i |=> (!chg_det_o && !chg_allow_o && sw_open_o && !dp_src_o));

  a_r3_det_needs_allow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_det_o |-> chg_allow_o);

  a_r4_src_needs_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_src_o |-> sw_open_o);

  a_r2_start_from_detect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chg_allow_o) |-> $past(det_done_i && bus_valid_i));

  a_r8_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_FAULT && bus_valid_i) |=> (phase_i == PH_FAULT));

  a_r7_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_TIMED && $past(phase_i) == PH_TIMED) |-> (tcnt_i >= $past(tcnt_i)));

endmodule

bind dbat_status_ctrl dbat_status_ctrl_chk #(.LIMIT_TICKS(LIMIT_TICKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_valid_i (bus_valid_i),
  .det_done_i  (det_done_i),
  .chg_det_o   (chg_det_o),
  .chg_allow_o (chg_allow_o),
  .sw_open_o   (sw_open_o),
  .dp_src_o    (dp_src_o),
  .phase_i     (phase_q),
  .tcnt_i      (tcnt)
);

// File: tb/dbat_status_ctrl_tb.sv
`timescale 1ns/1ps
module dbat_status_ctrl_tb;

  localparam int N = 4;
  localparam int L = 40;
  localparam int C = 3;
  localparam int O = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bv = 1'b0, det = 1'b0, gb = 1'b0;
  logic [1:0] pt = 2'b00;
  logic chg_det, chg_allow, sw_open, dp_src;

  int checks = 0, errors = 0;
  bit done = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  dbat_status_ctrl #(.CLK_PER_TICK(N), .LIMIT_TICKS(L), .CLOSE_TICKS(C), .OPEN_TICKS(O)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bv), .det_done_i(det),
    .port_type_i(pt), .good_bat_i(gb),
    .chg_det_o(chg_det), .chg_allow_o(chg_allow), .sw_open_o(sw_open), .dp_src_o(dp_src));

  // Behavioural reference: 0 idle, 1 timed, 2 held, 3 fault
  int m_ph, m_pre, m_t, m_ok, m_dc, m_port;

  always @(posedge clk or negedge rst_n) begin
    int ph, pre, t, ok, dc, port, lim;
    bit tick;
    if (!rst_n) begin
      m_ph = 0; m_pre = 0; m_t = 0; m_ok = 0; m_dc = 0; m_port = 0;
    end else begin
      ph = m_ph; pre = m_pre; t = m_t; ok = m_ok; dc = m_dc; port = m_port;
      tick = (m_ph != 0) && (m_pre == N - 1);
      pre = (m_ph == 0 || tick) ? 0 : m_pre + 1;
      if (m_ph == 0) t = 0;
      else if (m_ph == 1 && tick) t = m_t + 1;
      if (m_ph == 0) begin
        dc = 0;
        ok = (bv && det) ? int'(gb) : 0;
      end else if (m_ph == 3 || int'(gb) == m_ok) begin
        dc = 0;
      end else if (tick) begin
        lim = gb ? C : O;
        if (m_dc == lim - 1) begin ok = int'(gb); dc = 0; end
        else dc = m_dc + 1;
      end
      if (!bv) ph = 0;
      else if (m_ph == 0) begin
        if (det) begin ph = 1; port = int'(pt); end
      end else if (m_ph == 1) begin
        if (tick && m_t == L - 1) ph = (m_ok != 0) ? 2 : 3;
      end else if (m_ph == 2) begin
        if (m_ok == 0) ph = 3;
      end
      m_ph = ph; m_pre = pre; m_t = t; m_ok = ok; m_dc = dc; m_port = port;
    end
  end

  function automatic logic [3:0] model_out();
    logic [3:0] r;
    r = 4'b0010;
    if (m_ph == 1 || m_ph == 2) begin
      r[2] = 1'b1;
      r[3] = (m_port == 1) || (m_port == 2);
      if (m_port == 2) begin r[1] = 1'b1; r[0] = 1'b1; end
      else begin
        r[1] = (m_ok == 0);
        r[0] = (m_ok == 0) && (m_ph == 1);
      end
    end
    return r;
  endfunction

  function automatic logic [3:0] dut_out();
    return {chg_det, chg_allow, sw_open, dp_src};
  endfunction

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      if (cmp_on) begin
        checks++;
        if (dut_out() !== model_out()) begin
          errors++;
          $display("FAIL %s model compare: actual %b expected %b at %0t",
                   cur_req, dut_out(), model_out(), $time);
        end
      end
    end
  endtask

  task automatic expect_lit(string req, logic [3:0] exp);
    checks++;
    if (dut_out() !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, dut_out(), exp, $time);
    end
  endtask

  task automatic pulse_det(logic [1:0] p);
    pt = p; det = 1'b1;
    step(1);
    det = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  // Output order in literals: {chg_det, chg_allow, sw_open, dp_src}
  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    expect_lit("R1 reset", 4'b0010);
    cmp_on = 1;

    cur_req = "R1"; bv = 1'b1; gb = 1'b1;
    step(10);
    expect_lit("R1 no detection", 4'b0010);

    // Standard host, good battery, then excursions and low expiry
    cur_req = "R2"; pulse_det(2'b00);
    expect_lit("R2 std host good", 4'b0100);
    cur_req = "R6"; gb = 1'b0; step(8);
    expect_lit("R6 short low ignored", 4'b0100);
    gb = 1'b1; step(4);
    cur_req = "R4"; gb = 1'b0; step(30);
    expect_lit("R4 std host low battery", 4'b0111);
    cur_req = "R8"; step(200);
    expect_lit("R8 fault at expiry", 4'b0010);
    gb = 1'b1; pt = 2'b10; det = 1'b1; step(2); det = 1'b0; step(20);
    expect_lit("R8 fault ignores inputs", 4'b0010);
    cur_req = "R10"; bv = 1'b0; step(1);
    expect_lit("R10 fault cleared by bus loss", 4'b0010);
    step(3);

    // Reserved code behaves as standard host
    cur_req = "R2"; bv = 1'b1; gb = 1'b1; step(2);
    pulse_det(2'b11);
    expect_lit("R2 code 11 as std host", 4'b0100);
    cur_req = "R10"; bv = 1'b0; step(1);
    expect_lit("R10 release next edge", 4'b0010);
    step(2);

    // Charging host, dead battery at start, recovers, good at expiry
    cur_req = "R3"; bv = 1'b1; gb = 1'b0; step(2);
    pulse_det(2'b01);
    expect_lit("R3 charging host dead battery", 4'b1111);
    cur_req = "R6"; gb = 1'b1; step(16);
    expect_lit("R6 close after rise delay", 4'b1100);
    cur_req = "R9"; step(170);
    expect_lit("R9 good at expiry", 4'b1100);
    cur_req = "R11"; pulse_det(2'b10); step(5);
    expect_lit("R11 detect ignored when held", 4'b1100);
    cur_req = "R9"; gb = 1'b0; step(30);
    expect_lit("R9 fall after expiry faults", 4'b0010);
    bv = 1'b0; step(3);

    // Dedicated charger, exact expiry timing
    cur_req = "R5"; bv = 1'b1; gb = 1'b0; step(2);
    pulse_det(2'b10);
    expect_lit("R5 dedicated at accept", 4'b1111);
    gb = 1'b1; step(8); gb = 1'b0; step(8);
    expect_lit("R5 dedicated ignores battery", 4'b1111);
    cur_req = "R11"; pulse_det(2'b00);
    cur_req = "R7"; step(142);
    expect_lit("R7 one edge before expiry", 4'b1111);
    step(1);
    expect_lit("R7 expiry at limit tick", 4'b0010);

    // Bus loss mid-period then fresh detection
    cur_req = "R10"; bv = 1'b0; step(2);
    bv = 1'b1; gb = 1'b1; pulse_det(2'b00);
    step(50);
    bv = 1'b0; step(1);
    expect_lit("R10 bus loss while timed", 4'b0010);
    cur_req = "R1"; bv = 1'b1; step(2);
    expect_lit("R1 idle after bus return", 4'b0010);
    cur_req = "R10"; pulse_det(2'b00);
    step(164);
    expect_lit("R9 fresh period good expiry", 4'b0100);

    cmp_on = 0;
    finish_run();
  end

endmodule